// File: doc/BRIEF.md
# Priority Interrupt Line Router

The router places up to twelve chosen event sources onto the upper twelve lines of a sixteen-line core interrupt vector. Lines 0 to 3 are never driven. Each of lines 4 to 15 owns an 8-bit source number. The block watches the 128-bit event vector for low-to-high transitions. When the source chosen by a line rises, that line gives a single-clock pulse. Indices 0 to 3 of the event vector carry the four combined group events, and a line can select them like any other source.

Software sets up the routing through a plain 32-bit register port of four words. Each word packs the source numbers of four consecutive lines, one byte per line. Line `p` lives in word `p / 4`, byte `p mod 4`, so bits `(p mod 4)*8 +: 8` hold it. Word 0 would cover lines 0 to 3. Those lines cannot be routed, so word 0 is reserved.

None of the pins stream data. The event vector and the interrupt outputs are sampled levels with no valid or ready handshake, so there is no back-pressure: a pulse that the core misses is lost. Reads are combinational from `cfg_addr`. A write lands at the clock edge on which `cfg_wr_en` is high.

Top module: `pri_irq_router`

## Requirements
- R1: After reset, every source byte reads 0 and `irq_o` is 0.
- R2: `irq_o[3:0]` stays 0 under every event pattern.
- R3: If line `p` (4..15) selects source `s` below 128 and `events_i[s]` is sampled high at an edge after being sampled low at the edge before, then `irq_o[p]` is 1 for exactly the following clock cycle.
- R4: A write to word `w` (1..3) loads byte `k` of `cfg_wdata` into the source byte of line `4*w + k`. The new selection applies from the next edge onward.
- R5: Word 0 always reads 0, and writes to it change no routing.
- R6: A source byte from 128 to 255 keeps its line at 0 whatever the events do.
- R7: Sources 0 to 3 (the combined group events) can be routed like any other. A source held high gives only one pulse.
- R8: Several lines that select the same source all pulse in the same cycle.
- R9: Reading word `w` returns the four source bytes last written to it, with line `4*w` in bits 7:0.
- R10: Event history is cleared by reset, so an event already high when reset is released counts as a rising edge at the first edge after release.
- R11: Pointing a line at a source that is already high produces no pulse on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| events_i | input | 128 | Event levels, index = source number |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| irq_o | output | 16 | Core interrupt lines, pulse per routed rising edge |

## Verification
A wrong source byte shows in two ways. It reads back wrongly through `cfg_rdata` straight after the write edge. It also sends a pulse to the wrong line, or to none, in the cycle after the first event rise. A stale entry in the event history shows as a missing pulse, an extra pulse, or a pulse two cycles long, visible one cycle after the event changes. The bench rotates sources across all three routed words, includes combined sources and disabled codes, and looks at both the pulse cycle and the cycle after it.

// File: rtl/pirs_pkg.sv
package pirs_pkg;
  localparam int unsigned EVENTS_DFLT    = 128;
  localparam int unsigned LINES_DFLT     = 16;
  localparam int unsigned FIRST_DFLT     = 4;
  localparam int unsigned FIELD_W_DFLT   = 8;
  localparam int unsigned PER_WORD_DFLT  = 4;
  localparam int unsigned ADDR_W_DFLT    = 2;
endpackage

// File: rtl/pirs_sel_regs.sv
module pirs_sel_regs #(
  parameter int unsigned LINES    = 16,
  parameter int unsigned FIRST    = 4,
  parameter int unsigned FIELD_W  = 8,
  parameter int unsigned PER_WORD = 4,
  parameter int unsigned ADDR_W   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [FIELD_W*PER_WORD-1:0]   wdata,
  output logic [FIELD_W*PER_WORD-1:0]   rdata,
  output logic [LINES*FIELD_W-1:0]      sel_flat
);
  localparam int unsigned WORD_W    = FIELD_W * PER_WORD;
  localparam int unsigned WORDS     = LINES / PER_WORD;
  localparam int unsigned RSV_WORDS = FIRST / PER_WORD;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    localparam int unsigned WIDX = g / PER_WORD;
    localparam int unsigned OFF  = (g % PER_WORD) * FIELD_W;
    if (g < FIRST) begin : g_rsv
      assign sel_flat[g*FIELD_W +: FIELD_W] = '0;
    end else begin : g_fld
      logic [FIELD_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          q <= '0;
        else if (wr_en && addr == ADDR_W'(WIDX))
          q <= wdata[OFF +: FIELD_W];
      end
      assign sel_flat[g*FIELD_W +: FIELD_W] = q;

      // R4: the addressed byte lands in this line's field
      a_r4_field_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(WIDX)) |=> (q == $past(wdata[OFF +: FIELD_W])));
    end
  end

  always_comb begin
    rdata = '0;
    for (int w = 0; w < WORDS; w++)
      if (addr == ADDR_W'(w))
        rdata = sel_flat[w*WORD_W +: WORD_W];
  end

  // R5: writes to reserved words leave all routing untouched
  a_r5_reserved_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(addr) < RSV_WORDS) |=> $stable(sel_flat));
endmodule

// File: rtl/pirs_edge.sv
module pirs_edge #(
  parameter int unsigned N = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev_in,
  output logic [N-1:0] rise
);
  logic [N-1:0] ev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ev_q <= '0;
    else        ev_q <= ev_in;
  end

  assign rise = ev_in & ~ev_q;

  // R7: a source cannot show a rise on two consecutive edges
  a_r7_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/pirs_line_sel.sv
module pirs_line_sel #(
  parameter int unsigned N       = 128,
  parameter int unsigned FIELD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       rise,
  input  logic [FIELD_W-1:0] sel,
  output logic               pulse
);
  localparam int unsigned IDX_W = $clog2(N);

  logic in_range;
  assign in_range = int'(sel) < N;

  always_ff @(posedge clk) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= in_range && rise[sel[IDX_W-1:0]];
  end

  // R6: an out-of-range code never produces a pulse
  a_r6_disabled_code: assert property (@(posedge clk) disable iff (!rst_n)
    !in_range |=> !pulse);

  // R3: with a steady selection the pulse lasts one cycle
  a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && $stable(sel)) |=> !pulse);
endmodule

// File: rtl/pri_irq_router.sv
module pri_irq_router
  import pirs_pkg::*;
#(
  parameter int unsigned NUM_EVENTS = EVENTS_DFLT,
  parameter int unsigned LINES      = LINES_DFLT,
  parameter int unsigned FIRST      = FIRST_DFLT,
  parameter int unsigned FIELD_W    = FIELD_W_DFLT,
  parameter int unsigned PER_WORD   = PER_WORD_DFLT,
  parameter int unsigned ADDR_W     = ADDR_W_DFLT
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_EVENTS-1:0]       events_i,
  input  logic                        cfg_wr_en,
  input  logic [ADDR_W-1:0]           cfg_addr,
  input  logic [FIELD_W*PER_WORD-1:0] cfg_wdata,
  output logic [FIELD_W*PER_WORD-1:0] cfg_rdata,
  output logic [LINES-1:0]            irq_o
);
  logic [LINES*FIELD_W-1:0] sel_flat;
  logic [NUM_EVENTS-1:0]    rise;

  pirs_sel_regs #(
    .LINES(LINES), .FIRST(FIRST), .FIELD_W(FIELD_W),
    .PER_WORD(PER_WORD), .ADDR_W(ADDR_W)
  ) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .sel_flat(sel_flat)
  );

  pirs_edge #(.N(NUM_EVENTS)) i_edge (
    .clk(clk), .rst_n(rst_n), .ev_in(events_i), .rise(rise)
  );

  for (genvar g = 0; g < LINES; g++) begin : g_out
    if (g < FIRST) begin : g_tied
      assign irq_o[g] = 1'b0;
    end else begin : g_routed
      pirs_line_sel #(.N(NUM_EVENTS), .FIELD_W(FIELD_W)) i_line (
        .clk(clk), .rst_n(rst_n), .rise(rise),
        .sel(sel_flat[g*FIELD_W +: FIELD_W]), .pulse(irq_o[g])
      );
    end
  end
endmodule

// File: tb/test_pri_irq_router.sv
`timescale 1ns/1ps
module test_pri_irq_router;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [127:0] events_i;
  logic         cfg_wr_en;
  logic [1:0]   cfg_addr;
  logic [31:0]  cfg_wdata;
  logic [31:0]  cfg_rdata;
  logic [15:0]  irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pri_irq_router i_pri_irq_router (
    .clk(clk), .rst_n(rst_n), .events_i(events_i), .cfg_wr_en(cfg_wr_en),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_o(irq_o)
  );

  // {word, write data, event to raise, expected irq_o}
  localparam int NV = 10;
  localparam logic [57:0] VECS [NV] = '{
    {2'd0, 32'hFFFF_FFFF, 8'h00, 16'hFFF0},
    {2'd1, 32'h8003_1105, 8'h05, 16'h0010},
    {2'd2, 32'hFF7F_4005, 8'h05, 16'h0110},
    {2'd3, 32'h7F7F_0211, 8'h7F, 16'hC400},
    {2'd1, 32'h8003_1105, 8'h11, 16'h1020},
    {2'd0, 32'h1234_5678, 8'h03, 16'h0040},
    {2'd2, 32'h0140_4090, 8'h40, 16'h0600},
    {2'd3, 32'h0000_0000, 8'h00, 16'hF000},
    {2'd1, 32'h0404_0404, 8'h02, 16'h0000},
    {2'd3, 32'h6464_6464, 8'h64, 16'hF000}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    cyc();
    cfg_wr_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; events_i = '0; cfg_wr_en = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    events_i[0] = 1'b1;
    @(negedge clk); cyc(); cyc();
    check("R1 irq in reset", {16'b0, irq_o}, 32'h0);
    for (int w = 0; w < 4; w++) begin
      cfg_addr = 2'(w); #1;
      check("R1 reset fields", cfg_rdata, 32'h0);
    end
    rst_n = 1'b1;
    cyc();
    check("R10 high at release pulses", {16'b0, irq_o}, 32'h0000_FFF0);
    cyc();
    check("R7 held level no repeat", {16'b0, irq_o}, 32'h0);
    events_i[0] = 1'b0;
    cyc();

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  a;
      logic [31:0] d;
      logic [7:0]  e;
      logic [15:0] x;
      {a, d, e, x} = VECS[i];
      wr(a, d);
      cfg_addr = a; #1;
      check("R4/R5/R9 readback", cfg_rdata, (a == 2'd0) ? 32'h0 : d);
      events_i[e] = 1'b1;
      cyc();
      check("R3/R6/R8 pulse", {16'b0, irq_o}, {16'b0, x});
      cyc();
      check("R3 pulse one cycle", {16'b0, irq_o}, 32'h0);
      events_i[e] = 1'b0;
      cyc();
      check("R3 no pulse on fall", {16'b0, irq_o}, 32'h0);
    end

    // R6 and R2: every event rises together, word 1 fully disabled
    wr(2'd1, 32'hFF80_81C0);
    events_i = '1;
    cyc();
    check("R6 disabled codes", {16'b0, irq_o}, 32'h0000_FE00);
    check("R2 low lines", {28'b0, irq_o[3:0]}, 32'h0);
    cyc();
    check("R7 level held", {16'b0, irq_o}, 32'h0);
    events_i = '0;
    cyc();

    // R11: reselecting onto a source that is already high
    wr(2'd1, 32'h0000_0014);
    events_i[20] = 1'b1;
    cyc();
    check("R11 first pulse", {16'b0, irq_o}, 32'h0000_0010);
    cyc();
    wr(2'd1, 32'h0000_1400);
    check("R11 write edge quiet", {16'b0, irq_o}, 32'h0);
    cyc();
    check("R11 reselect quiet", {16'b0, irq_o}, 32'h0);
    events_i[20] = 1'b0;
    cyc();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule